// File: doc/BRIEF.md
# Vector Element Insert Unit

This block is one execute stage for a group of four vector insert operations on 128-bit vector registers. It receives a 32-bit instruction word, the current value of the destination register, the current value of the source register and a flag that says whether the vector unit is enabled. It decodes the instruction and takes one element of 1, 2, 4 or 8 bytes from a fixed slot of the source register. It then writes that element into a copy of the destination register, starting at a byte offset given by an immediate. Every other destination byte keeps its old value.

Bad encodings raise an illegal-instruction code. A disabled unit raises an unavailable code and blocks the write. The result, the write-enable, both register numbers and a one-hot exception code come out of a register one cycle after the instruction is presented. The register file and hazard handling sit outside the block. Both register values must be read before the operation starts.

Top module: `vec_insert_unit`

## Requirements
- R1: An instruction is an insert only if all of the following hold. Bits 31..26 equal 4. Bits 5..0 equal 6'b001101. Bits 10..6 hold a minor code from 12 to 15. Codes 12, 13, 14 and 15 select element sizes of 1, 2, 4 and 8 bytes. Any other word is illegal.
- R2: Vector bytes are numbered big-endian, with byte 0 at bits 127..120 and byte 15 at bits 7..0. The inserted element is always source bytes 8-size through 7, which is source bits [64 +: 8*size].
- R3: The element is written into destination bytes off through off+size-1, where off is the immediate in instruction bits 19..16.
- R4: An immediate greater than 16-size is replaced by offset 0.
- R5: Every destination byte outside the written element keeps its old value.
- R6: The result is correct when the source and destination inputs carry the same vector, so that the two registers are aliased.
- R7: A set instruction bit 20 makes any insert form illegal, and no write takes place.
- R8: A low unit-enable gives the unavailable exception and no write. This code takes priority over the illegal code.
- R9: One cycle after a valid input, outValid is high. At the same time result and wrEn are presented, dstReg carries instruction bits 25..21 and srcReg carries bits 15..11.
- R10: excCode is one-hot, with bit 0 for none, bit 1 for illegal and bit 2 for unavailable. wrEn is low whenever an exception is flagged. In that case result equals the old destination value.
- R11: After reset, outValid and wrEn are 0, excCode is 3'b001 and result is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| inValid | input | 1 | Instruction and operands are valid this cycle |
| instr | input | 32 | Instruction word |
| vdOld | input | 128 | Current destination register value |
| vbOld | input | 128 | Current source register value |
| unitEnable | input | 1 | Vector unit enabled |
| outValid | output | 1 | Registered result is valid |
| result | output | 128 | New destination value |
| wrEn | output | 1 | Write the result to the destination register |
| dstReg | output | 5 | Destination register number |
| srcReg | output | 5 | Source register number |
| excCode | output | 3 | One-hot exception code: none, illegal, unavailable |

## Verification
The bench runs every element size against every immediate from 0 to 15. A design that clamps wrongly writes past byte 15 or leaves the element at the raw immediate. A design that takes the source slot from the wrong half, or indexes bytes little-endian, produces shifted or mirrored bytes.

An aliasing case feeds the same vector to both operands. A datapath that merged in place before sampling the source would move bytes that had already been overwritten.

A set bit 20 and a disabled unit are each applied, both alone and together. A design that ignored either case would assert wrEn or report the wrong exception priority. A wrong primary opcode and a wrong minor code must both be rejected as illegal.

// File: rtl/vins_pkg.sv
package vins_pkg;
  parameter int VEC_BYTES = 16;
  parameter int INSTR_W   = 32;
  parameter int REG_W     = 5;
  localparam int VEC_W    = VEC_BYTES * 8;
  localparam int OFF_W    = $clog2(VEC_BYTES);
  localparam int HALF     = VEC_BYTES / 2;
  localparam int SIZE_LW  = 2;
  localparam int EXC_W    = 3;

  localparam logic [5:0] PRIMARY_OP = 6'd4;
  localparam logic [5:0] LOW_FIELD  = 6'b001101;
  localparam logic [4:0] MINOR_BASE = 5'd12;

  localparam logic [EXC_W-1:0] EXC_NONE    = 3'b001;
  localparam logic [EXC_W-1:0] EXC_ILLEGAL = 3'b010;
  localparam logic [EXC_W-1:0] EXC_UNAVAIL = 3'b100;

  typedef struct packed {
    logic              fire;
    logic [SIZE_LW-1:0] sizeLog;
    logic [OFF_W-1:0]  offset;
    logic [EXC_W-1:0]  exc;
    logic [REG_W-1:0]  dst;
    logic [REG_W-1:0]  src;
  } insCtrl_t;
endpackage

// File: rtl/vins_ctrl.sv
module vins_ctrl
  import vins_pkg::*;
(
  input  logic               inValid,
  input  logic [INSTR_W-1:0] instr,
  input  logic               unitEnable,
  output insCtrl_t           ctrl
);
  logic [5:0] primaryOp;
  logic [4:0] minorOp;
  logic [5:0] lowField;
  logic       rsvdBit;
  logic [OFF_W-1:0] rawImm;
  logic [SIZE_LW-1:0] sizeLog;
  logic       minorOk;
  logic       encodingOk;
  logic [OFF_W:0] sizeBytes;
  logic [OFF_W:0] limit;
  logic [EXC_W-1:0] excSel;

  assign primaryOp = instr[31:26];
  assign minorOp   = instr[10:6];
  assign lowField  = instr[5:0];
  assign rsvdBit   = instr[20];
  assign rawImm    = instr[19:16];

  assign minorOk    = (minorOp >= MINOR_BASE) && (minorOp <= MINOR_BASE + 5'd3);
  assign sizeLog    = SIZE_LW'(minorOp - MINOR_BASE);
  assign encodingOk = (primaryOp == PRIMARY_OP) && (lowField == LOW_FIELD)
                      && minorOk && !rsvdBit;

  assign sizeBytes = (OFF_W+1)'(1) << sizeLog;
  assign limit     = (OFF_W+1)'(VEC_BYTES) - sizeBytes;

  always_comb begin
    if (!unitEnable)      excSel = EXC_UNAVAIL;
    else if (!encodingOk) excSel = EXC_ILLEGAL;
    else                  excSel = EXC_NONE;
  end

  always_comb begin
    ctrl.fire    = inValid && (excSel == EXC_NONE);
    ctrl.sizeLog = sizeLog;
    ctrl.offset  = ({1'b0, rawImm} > limit) ? '0 : rawImm;
    ctrl.exc     = excSel;
    ctrl.dst     = instr[25:21];
    ctrl.src     = instr[15:11];
  end
endmodule

// File: rtl/vins_datapath.sv
module vins_datapath
  import vins_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inValid,
  input  insCtrl_t         ctrl,
  input  logic [VEC_W-1:0] vdOld,
  input  logic [VEC_W-1:0] vbOld,
  output logic             outValid,
  output logic [VEC_W-1:0] result,
  output logic             wrEn,
  output logic [REG_W-1:0] dstReg,
  output logic [REG_W-1:0] srcReg,
  output logic [EXC_W-1:0] excCode
);
  logic [7:0] vdB [VEC_BYTES];
  logic [7:0] vbB [VEC_BYTES];
  logic [VEC_W-1:0] merged;

  // big-endian byte views of both operands, taken before any merge
  for (genvar g = 0; g < VEC_BYTES; g++) begin : g_bytes
    assign vdB[g] = vdOld[(VEC_BYTES-1-g)*8 +: 8];
    assign vbB[g] = vbOld[(VEC_BYTES-1-g)*8 +: 8];
  end

  always_comb begin
    int sz;
    int lo;
    int srcIdx;
    sz = 1 << ctrl.sizeLog;
    lo = int'(ctrl.offset);
    merged = '0;
    for (int j = 0; j < VEC_BYTES; j++) begin
      srcIdx = HALF - sz + j - lo;
      if (j >= lo && j < lo + sz)
        merged[(VEC_BYTES-1-j)*8 +: 8] = vbB[srcIdx[OFF_W-1:0]];
      else
        merged[(VEC_BYTES-1-j)*8 +: 8] = vdB[j];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outValid <= 1'b0;
      result   <= '0;
      wrEn     <= 1'b0;
      dstReg   <= '0;
      srcReg   <= '0;
      excCode  <= EXC_NONE;
    end else begin
      outValid <= inValid;
      wrEn     <= ctrl.fire;
      if (inValid) begin
        result  <= ctrl.fire ? merged : vdOld;
        dstReg  <= ctrl.dst;
        srcReg  <= ctrl.src;
        excCode <= ctrl.exc;
      end else begin
        excCode <= EXC_NONE;
      end
    end
  end
endmodule

// File: rtl/vec_insert_unit.sv
module vec_insert_unit
  import vins_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               inValid,
  input  logic [INSTR_W-1:0] instr,
  input  logic [VEC_W-1:0]   vdOld,
  input  logic [VEC_W-1:0]   vbOld,
  input  logic               unitEnable,
  output logic               outValid,
  output logic [VEC_W-1:0]   result,
  output logic               wrEn,
  output logic [REG_W-1:0]   dstReg,
  output logic [REG_W-1:0]   srcReg,
  output logic [EXC_W-1:0]   excCode
);
  insCtrl_t ctrl;

  vins_ctrl ctrl_i (
    .inValid    (inValid),
    .instr      (instr),
    .unitEnable (unitEnable),
    .ctrl       (ctrl)
  );

  vins_datapath dp_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .inValid  (inValid),
    .ctrl     (ctrl),
    .vdOld    (vdOld),
    .vbOld    (vbOld),
    .outValid (outValid),
    .result   (result),
    .wrEn     (wrEn),
    .dstReg   (dstReg),
    .srcReg   (srcReg),
    .excCode  (excCode)
  );
endmodule

// File: rtl/vins_checker.sv
module vins_checker
  import vins_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               inValid,
  input logic [INSTR_W-1:0] instr,
  input logic [VEC_W-1:0]   vdOld,
  input logic               unitEnable,
  input logic               outValid,
  input logic [VEC_W-1:0]   result,
  input logic               wrEn,
  input logic [REG_W-1:0]   dstReg,
  input logic [EXC_W-1:0]   excCode
);
  AST_EXC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(excCode) == 1); // R10

  AST_WREN_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    wrEn |-> (excCode == EXC_NONE) && outValid); // R10

  AST_DISABLED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    inValid && !unitEnable |=> !wrEn && excCode == EXC_UNAVAIL); // R8

  AST_DISABLED_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    inValid && !unitEnable |=> result == $past(vdOld)); // R10

  AST_RSVD_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    inValid && unitEnable && instr[20] |=> !wrEn && excCode == EXC_ILLEGAL); // R7

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> outValid); // R9

  AST_DST_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> dstReg == $past(instr[25:21])); // R9
endmodule

bind vec_insert_unit vins_checker chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .inValid    (inValid),
  .instr      (instr),
  .vdOld      (vdOld),
  .unitEnable (unitEnable),
  .outValid   (outValid),
  .result     (result),
  .wrEn       (wrEn),
  .dstReg     (dstReg),
  .excCode    (excCode)
);

// File: tb/vec_insert_unit_tb.sv
module vec_insert_unit_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         inValid = 1'b0;
  logic [31:0]  instr = '0;
  logic [127:0] vdOld = '0;
  logic [127:0] vbOld = '0;
  logic         unitEnable = 1'b1;
  logic         outValid;
  logic [127:0] result;
  logic         wrEn;
  logic [4:0]   dstReg;
  logic [4:0]   srcReg;
  logic [2:0]   excCode;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  vec_insert_unit dut_i (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .instr(instr),
    .vdOld(vdOld), .vbOld(vbOld), .unitEnable(unitEnable),
    .outValid(outValid), .result(result), .wrEn(wrEn),
    .dstReg(dstReg), .srcReg(srcReg), .excCode(excCode)
  );

  function automatic logic [31:0] mkInstr(input int sl, input int imm,
      input int dst, input int src, input bit rsvd);
    return {6'd4, 5'(dst), rsvd, 4'(imm), 5'(src), 5'(12 + sl), 6'b001101};
  endfunction

  function automatic logic [127:0] refIns(input logic [127:0] vd,
      input logic [127:0] vb, input int sl, input int imm);
    logic [7:0] d [16];
    logic [7:0] b [16];
    logic [127:0] r;
    int s;
    int o;
    s = 1 << sl;
    o = (imm > 16 - s) ? 0 : imm;
    for (int k = 0; k < 16; k++) begin
      d[k] = vd[127-8*k -: 8];
      b[k] = vb[127-8*k -: 8];
    end
    for (int m = 0; m < s; m++) d[o+m] = b[8-s+m];
    for (int k = 0; k < 16; k++) r[127-8*k -: 8] = d[k];
    return r;
  endfunction

  task automatic check(input string req, input logic [127:0] act,
      input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] ins, input logic [127:0] vd,
      input logic [127:0] vb, input bit en);
    @(negedge clk);
    inValid = 1'b1; instr = ins; vdOld = vd; vbOld = vb; unitEnable = en;
    @(negedge clk);
    inValid = 1'b0; unitEnable = 1'b1;
  endtask

  task automatic testReset();
    check("R11 outValid", 128'(outValid), 128'(0));
    check("R11 wrEn", 128'(wrEn), 128'(0));
    check("R11 excCode", 128'(excCode), 128'(3'b001));
    check("R11 result", result, 128'(0));
  endtask

  task automatic testSweep();
    for (int sl = 0; sl < 4; sl++) begin
      for (int imm = 0; imm < 16; imm++) begin
        logic [127:0] vd;
        logic [127:0] vb;
        vd = {4{32'hD0D1D2D3 + 32'(imm * 16 + sl)}};
        vb = 128'h00112233_44556677_8899AABB_CCDDEEFF ^ {16{8'(sl * 17)}};
        issue(mkInstr(sl, imm, 3, 7, 1'b0), vd, vb, 1'b1);
        // R2 R3 R4 R5: element from bytes 8-size..7 placed at clamped offset
        check("R3 R4 R5 sweep result", result, refIns(vd, vb, sl, imm));
        check("R2 sweep wrEn", 128'({wrEn, excCode}), 128'({1'b1, 3'b001}));
      end
    end
  endtask

  task automatic testAlias();
    logic [127:0] v;
    v = 128'h0102030405060708_090A0B0C0D0E0F10;
    issue(mkInstr(3, 8, 9, 9, 1'b0), v, v, 1'b1);
    check("R6 alias dword", result, 128'h0102030405060708_0102030405060708);
    issue(mkInstr(2, 0, 9, 9, 1'b0), v, v, 1'b1);
    check("R6 alias word", result, 128'h0506070805060708_090A0B0C0D0E0F10);
  endtask

  task automatic testReserved();
    logic [127:0] vd;
    vd = {4{32'hCAFEF00D}};
    issue(mkInstr(1, 4, 2, 5, 1'b1), vd, '1, 1'b1);
    check("R7 rsvd exc", 128'(excCode), 128'(3'b010));
    check("R7 rsvd wrEn", 128'(wrEn), 128'(0));
    check("R7 R10 rsvd result", result, vd);
  endtask

  task automatic testDisabled();
    logic [127:0] vd;
    vd = {4{32'h13579BDF}};
    issue(mkInstr(0, 3, 4, 6, 1'b0), vd, '0, 1'b0);
    check("R8 disabled exc", 128'(excCode), 128'(3'b100));
    check("R8 disabled wrEn", 128'(wrEn), 128'(0));
    check("R10 disabled result", result, vd);
    issue(mkInstr(0, 3, 4, 6, 1'b1), vd, '0, 1'b0);
    check("R8 priority over illegal", 128'(excCode), 128'(3'b100));
  endtask

  task automatic testBadOpcode();
    logic [31:0] ins;
    ins = mkInstr(0, 1, 1, 1, 1'b0);
    ins[31:26] = 6'd5;
    issue(ins, '0, '1, 1'b1);
    check("R1 bad primary", 128'({wrEn, excCode}), 128'({1'b0, 3'b010}));
    ins = mkInstr(0, 1, 1, 1, 1'b0);
    ins[10:6] = 5'd11;
    issue(ins, '0, '1, 1'b1);
    check("R1 bad minor", 128'({wrEn, excCode}), 128'({1'b0, 3'b010}));
    ins = mkInstr(0, 1, 1, 1, 1'b0);
    ins[0] = 1'b0;
    issue(ins, '0, '1, 1'b1);
    check("R1 bad low field", 128'(excCode), 128'(3'b010));
  endtask

  task automatic testFields();
    issue(mkInstr(2, 4, 27, 14, 1'b0), '0, '1, 1'b1);
    check("R9 outValid", 128'(outValid), 128'(1));
    check("R9 dstReg", 128'(dstReg), 128'(27));
    check("R9 srcReg", 128'(srcReg), 128'(14));
    @(negedge clk);
    check("R9 outValid drops", 128'(outValid), 128'(0));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rst_n = 1'b1;
    @(negedge clk);
    testSweep();
    testAlias();
    testReserved();
    testDisabled();
    testBadOpcode();
    testFields();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule